// File: doc/BRIEF.md
# Transmit Reset Sequencer

This controller brings the transmit side of a serial transceiver out of reset in a fixed order. It pulses the physical-medium reset. It waits for the transmit PLL and the user clocks to settle. It then raises a phase-alignment request for a fixed window, pulses the coding-sublayer reset and allows a short settle time. After that it reports completion. If the transmit PLL loses lock at any point during the alignment, coding reset or settle phases, the sequence falls back to the lock wait, and the full wait time applies again.

In systems where the transmit PLL takes its reference from recovered receive clocks, an optional gate holds the sequence at its start until the receive PLL is trusted. With analog clock recovery, the receive lock must have stayed high for a long unbroken run of cycles. With digital recovery, a high receive lock is enough. All inputs are taken as already synchronous to `clk`. The system reset is synchronous and active high.

Top module: `tx_rst_seq`

## Requirements
- R1: While `sys_rst` is high, `pma_rst`, `pcs_rst`, `sync_req` and `done` are all low one cycle later, whatever state the sequence was in.
- R2: With `rx_gate_en` low, the first clock edge after `sys_rst` falls raises `pma_rst`.
- R3: `pma_rst` stays high for exactly PMA_CYCLES clock cycles (default 3), and then falls with all other outputs low.
- R4: After the physical-medium reset, the sequence waits until `tx_lock` and `usrclk_ok` are both high. It then needs LOCK_WAIT consecutive cycles (default 12000) with both high before `sync_req` rises. A drop of either input restarts that count.
- R5: `sync_req` stays high for exactly SYNC_CYCLES cycles (default 64) when `tx_lock` holds, and `pcs_rst` rises on the cycle it falls.
- R6: `pcs_rst` stays high for exactly PCS_CYCLES cycles (default 3) when `tx_lock` holds.
- R7: After `pcs_rst` falls, all outputs stay low for SETTLE_CYCLES cycles (default 5). Then `done` rises and stays high until `sys_rst`.
- R8: A low `tx_lock` while `sync_req` or `pcs_rst` is high, or during the settle phase, brings all outputs low on the next cycle and returns to the lock wait of R4, which then takes its full length again.
- R9: With `rx_gate_en` high and `cdr_digital` low (analog recovery), `pma_rst` rises only after `rx_lock` has been high on RX_STABLE consecutive edges (default 16384) since reset. It rises on the edge after the last of these. A low `rx_lock` restarts the run from zero.
- R10: With `rx_gate_en` high and `cdr_digital` high (digital recovery), `pma_rst` rises on the first edge after reset release at which `rx_lock` is high.
- R11: At most one of `pma_rst`, `pcs_rst`, `sync_req` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock (user clock of the transmit path) |
| sys_rst | input | 1 | Synchronous active-high system reset |
| tx_lock | input | 1 | Transmit PLL lock indication |
| usrclk_ok | input | 1 | User clocks reported stable |
| rx_lock | input | 1 | Receive PLL lock indication |
| rx_gate_en | input | 1 | 1: start of sequence waits for receive lock |
| cdr_digital | input | 1 | 1: digital clock recovery, 0: analog clock recovery |
| pma_rst | output | 1 | Physical-medium reset to the transceiver |
| pcs_rst | output | 1 | Coding-sublayer reset to the transceiver |
| sync_req | output | 1 | Transmit phase-alignment request |
| done | output | 1 | Sequence complete |

## Verification
The assertions watch properties that hold on every cycle: the output exclusivity, the exact widths of the three pulses (measured by run counters in the checker), the quieting of outputs under reset and after a transmit lock loss, the stickiness of `done`, and, for both recovery modes, the receive-lock condition at the moment the physical-medium reset starts. Some behaviours can only be shown by the bench scenarios. These are the length of the lock wait and its restart when `usrclk_ok` drops, the full re-wait after a lock loss in each of the late phases, and the restart of the analog receive-lock run after a brief drop.

// File: rtl/tx_rst_seq_pkg.sv
package tx_rst_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PMA    = 3'd1,
      ST_WLOCK  = 3'd2,
      ST_ALIGN  = 3'd3,
      ST_PCS    = 3'd4,
      ST_SETTLE = 3'd5,
      ST_DONE   = 3'd6
   } seq_st_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tx_rst_rxqual.sv
module tx_rst_rxqual #(
   parameter int RX_STABLE = 16384,
   parameter bit USE_RUN   = 1'b1
) (
   input  logic clk,
   input  logic sys_rst,
   input  logic rx_lock,
   output logic rx_trusted
);

   generate
      if (USE_RUN) begin : g_run
         localparam int RW = $clog2(RX_STABLE + 1);
         localparam logic [RW-1:0] RLIM = RW'(RX_STABLE);
         logic [RW-1:0] run_q;

         always_ff @(posedge clk) begin
            if (sys_rst || !rx_lock) begin
               run_q <= '0;
            end else if (run_q != RLIM) begin
               run_q <= run_q + 1'b1;
            end
         end

         assign rx_trusted = (run_q == RLIM);
      end else begin : g_level
         assign rx_trusted = rx_lock;
      end
   endgenerate

endmodule

// File: rtl/tx_rst_timer.sv
module tx_rst_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/tx_rst_seq.sv
module tx_rst_seq
   import tx_rst_seq_pkg::*;
#(
   parameter int PMA_CYCLES    = 3,
   parameter int LOCK_WAIT     = 12000,
   parameter int SYNC_CYCLES   = 64,
   parameter int PCS_CYCLES    = 3,
   parameter int SETTLE_CYCLES = 5,
   parameter int RX_STABLE     = 16384,
   parameter bit HAS_RX_RUN    = 1'b1
) (
   input  logic clk,
   input  logic sys_rst,
   input  logic tx_lock,
   input  logic usrclk_ok,
   input  logic rx_lock,
   input  logic rx_gate_en,
   input  logic cdr_digital,
   output logic pma_rst,
   output logic pcs_rst,
   output logic sync_req,
   output logic done
);

   localparam int MAXC = max2(max2(max2(PMA_CYCLES, LOCK_WAIT), max2(SYNC_CYCLES, PCS_CYCLES)),
                              SETTLE_CYCLES);
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (PMA_CYCLES < 1 || LOCK_WAIT < 1 || SYNC_CYCLES < 1 ||
          PCS_CYCLES < 1 || SETTLE_CYCLES < 1 || RX_STABLE < 1) begin : g_bad_param
         $error("tx_rst_seq: every phase length must be at least 1");
      end
   endgenerate

   seq_st_t       st_q, st_d;
   logic [CW-1:0] tcnt;
   logic [CW-1:0] tlim;
   logic          tlast;
   logic          tclr;
   logic          tinc;
   logic          rx_run_ok;
   logic          rx_ok;
   logic          tx_qual;

   tx_rst_rxqual #(
      .RX_STABLE (RX_STABLE),
      .USE_RUN   (HAS_RX_RUN)
   ) i_rxqual (
      .clk        (clk),
      .sys_rst    (sys_rst),
      .rx_lock    (rx_lock),
      .rx_trusted (rx_run_ok)
   );

   tx_rst_timer #(
      .CW (CW)
   ) i_timer (
      .clk (clk),
      .clr (tclr),
      .inc (tinc),
      .cnt (tcnt)
   );

   assign rx_ok   = !rx_gate_en || (cdr_digital ? rx_lock : rx_run_ok);
   assign tx_qual = tx_lock && usrclk_ok;

   always_comb begin
      case (st_q)
         ST_PMA:    tlim = CW'(PMA_CYCLES);
         ST_WLOCK:  tlim = CW'(LOCK_WAIT);
         ST_ALIGN:  tlim = CW'(SYNC_CYCLES);
         ST_PCS:    tlim = CW'(PCS_CYCLES);
         ST_SETTLE: tlim = CW'(SETTLE_CYCLES);
         default:   tlim = CW'(1);
      endcase
   end

   assign tlast = (tcnt == tlim - 1'b1);

   always_comb begin
      st_d = st_q;
      tinc = 1'b1;
      case (st_q)
         ST_IDLE: begin
            if (rx_ok) st_d = ST_PMA;
         end
         ST_PMA: begin
            if (tlast) st_d = ST_WLOCK;
         end
         ST_WLOCK: begin
            if (!tx_qual) tinc = 1'b0;
            else if (tlast) st_d = ST_ALIGN;
         end
         ST_ALIGN: begin
            if (!tx_lock) st_d = ST_WLOCK;
            else if (tlast) st_d = ST_PCS;
         end
         ST_PCS: begin
            if (!tx_lock) st_d = ST_WLOCK;
            else if (tlast) st_d = ST_SETTLE;
         end
         ST_SETTLE: begin
            if (!tx_lock) st_d = ST_WLOCK;
            else if (tlast) st_d = ST_DONE;
         end
         ST_DONE: begin
            tinc = 1'b0;
         end
         default: begin
            st_d = ST_IDLE;
         end
      endcase
      if (sys_rst) st_d = ST_IDLE;
   end

   assign tclr = sys_rst || (st_d != st_q) || (st_q == ST_WLOCK && !tx_qual);

   always_ff @(posedge clk) begin
      if (sys_rst) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign pma_rst  = (st_q == ST_PMA);
   assign pcs_rst  = (st_q == ST_PCS);
   assign sync_req = (st_q == ST_ALIGN);
   assign done     = (st_q == ST_DONE);

endmodule

// File: rtl/tx_rst_seq_chk.sv
module tx_rst_seq_chk #(
   parameter int PMA_CYCLES  = 3,
   parameter int SYNC_CYCLES = 64,
   parameter int PCS_CYCLES  = 3,
   parameter int RX_STABLE   = 16384
) (
   input logic clk,
   input logic sys_rst,
   input logic tx_lock,
   input logic rx_lock,
   input logic rx_gate_en,
   input logic cdr_digital,
   input logic pma_rst,
   input logic pcs_rst,
   input logic sync_req,
   input logic done
);

   int pma_run;
   int pcs_run;
   int sync_run;
   int rx_run;

   always_ff @(posedge clk) begin
      if (sys_rst) begin
         pma_run  <= 0;
         pcs_run  <= 0;
         sync_run <= 0;
         rx_run   <= 0;
      end else begin
         pma_run  <= pma_rst  ? pma_run + 1  : 0;
         pcs_run  <= pcs_rst  ? pcs_run + 1  : 0;
         sync_run <= sync_req ? sync_run + 1 : 0;
         if (!rx_lock)               rx_run <= 0;
         else if (rx_run < RX_STABLE) rx_run <= rx_run + 1;
      end
   end

   AST_RST_QUIET: assert property (@(posedge clk)
      sys_rst |=> !pma_rst && !pcs_rst && !sync_req && !done); // R1

   AST_PMA_WIDTH: assert property (@(posedge clk) disable iff (sys_rst)
      $fell(pma_rst) && !$past(sys_rst) |-> pma_run == PMA_CYCLES); // R3

   AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (sys_rst)
      $fell(sync_req) && !$past(sys_rst) && $past(tx_lock) |-> sync_run == SYNC_CYCLES && pcs_rst); // R5

   AST_PCS_WIDTH: assert property (@(posedge clk) disable iff (sys_rst)
      $fell(pcs_rst) && !$past(sys_rst) && $past(tx_lock) |-> pcs_run == PCS_CYCLES); // R6

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (sys_rst)
      done |=> done); // R7

   AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (sys_rst)
      (sync_req || pcs_rst) && !tx_lock |=> !sync_req && !pcs_rst && !done); // R8

   AST_RX_ANALOG: assert property (@(posedge clk) disable iff (sys_rst)
      $rose(pma_rst) && $past(rx_gate_en) && !$past(cdr_digital) |-> $past(rx_run) >= RX_STABLE); // R9

   AST_RX_DIGITAL: assert property (@(posedge clk) disable iff (sys_rst)
      $rose(pma_rst) && $past(rx_gate_en) && $past(cdr_digital) |-> $past(rx_lock)); // R10

   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (sys_rst)
      $onehot0({pma_rst, pcs_rst, sync_req, done})); // R11

endmodule

bind tx_rst_seq tx_rst_seq_chk #(
   .PMA_CYCLES  (PMA_CYCLES),
   .SYNC_CYCLES (SYNC_CYCLES),
   .PCS_CYCLES  (PCS_CYCLES),
   .RX_STABLE   (RX_STABLE)
) i_chk (
   .clk         (clk),
   .sys_rst     (sys_rst),
   .tx_lock     (tx_lock),
   .rx_lock     (rx_lock),
   .rx_gate_en  (rx_gate_en),
   .cdr_digital (cdr_digital),
   .pma_rst     (pma_rst),
   .pcs_rst     (pcs_rst),
   .sync_req    (sync_req),
   .done        (done)
);

// File: tb/test_tx_rst_seq.sv
module test_tx_rst_seq;

   localparam int LW  = 20;
   localparam int RXS = 16;

   logic clk = 1'b0;
   logic sys_rst = 1'b1;
   logic tx_lock = 1'b0;
   logic usrclk_ok = 1'b0;
   logic rx_lock = 1'b0;
   logic rx_gate_en = 1'b0;
   logic cdr_digital = 1'b0;
   logic pma_rst, pcs_rst, sync_req, done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tx_rst_seq #(
      .LOCK_WAIT (LW),
      .RX_STABLE (RXS)
   ) i_tx_rst_seq (
      .clk         (clk),
      .sys_rst     (sys_rst),
      .tx_lock     (tx_lock),
      .usrclk_ok   (usrclk_ok),
      .rx_lock     (rx_lock),
      .rx_gate_en  (rx_gate_en),
      .cdr_digital (cdr_digital),
      .pma_rst     (pma_rst),
      .pcs_rst     (pcs_rst),
      .sync_req    (sync_req),
      .done        (done)
   );

   // row: {sys_rst, tx_lock, usrclk_ok, rx_lock, gate, digital}, cycles, expected {pma,pcs,sync,done}
   localparam int NV = 14;
   localparam logic [17:0] VEC [NV] = '{
      {6'b100000, 8'd3,  4'b0000},  // R1 reset
      {6'b000000, 8'd1,  4'b1000},  // R2 start
      {6'b000000, 8'd2,  4'b1000},  // R3 width
      {6'b000000, 8'd1,  4'b0000},  // R3 fall
      {6'b000000, 8'd30, 4'b0000},  // R4 stall
      {6'b011000, 8'd19, 4'b0000},  // R4 count
      {6'b011000, 8'd1,  4'b0010},  // R4 enter align
      {6'b011000, 8'd63, 4'b0010},  // R5 width
      {6'b011000, 8'd1,  4'b0100},  // R5 to pcs
      {6'b011000, 8'd2,  4'b0100},  // R6 width
      {6'b011000, 8'd1,  4'b0000},  // R6 fall
      {6'b011000, 8'd4,  4'b0000},  // R7 settle
      {6'b011000, 8'd1,  4'b0001},  // R7 done
      {6'b011000, 8'd10, 4'b0001}   // R7 hold
   };

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic [3:0] exp, input string req);
      logic [3:0] act;
      act = {pma_rst, pcs_rst, sync_req, done};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: outputs {pma,pcs,sync,done} = %b, expected %b", req, act, exp);
      end
   endtask

   task automatic restart(input logic txl, input logic ck, input logic rxl,
                          input logic gate, input logic dig);
      sys_rst = 1'b1;
      tx_lock = txl; usrclk_ok = ck; rx_lock = rxl;
      rx_gate_en = gate; cdr_digital = dig;
      run(2);
      sys_rst = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         {sys_rst, tx_lock, usrclk_ok, rx_lock, rx_gate_en, cdr_digital} = VEC[i][17:12];
         run(int'(VEC[i][11:4]));
         chk(VEC[i][3:0], $sformatf("R%0d vector %0d", (i < 1) ? 1 : (i < 2) ? 2 : (i < 4) ? 3 :
                                    (i < 7) ? 4 : (i < 9) ? 5 : (i < 11) ? 6 : 7, i));
      end

      // R1: reset from done and from alignment
      sys_rst = 1'b1; run(1); chk(4'b0000, "R1 reset from done");
      restart(1, 1, 0, 0, 0);
      run(24); chk(4'b0010, "R5 align reached");
      sys_rst = 1'b1; run(1); chk(4'b0000, "R1 reset from align");

      // R8: lock loss during alignment
      restart(1, 1, 0, 0, 0);
      run(24); chk(4'b0010, "R8 align before loss");
      tx_lock = 1'b0; run(1); chk(4'b0000, "R8 loss in align");
      tx_lock = 1'b1; run(19); chk(4'b0000, "R8 full rewait");
      run(1); chk(4'b0010, "R8 align again");

      // R4: usrclk_ok drop restarts the lock wait
      restart(1, 1, 0, 0, 0);
      run(4); chk(4'b0000, "R4 in lock wait");
      run(10);
      usrclk_ok = 1'b0; run(1); chk(4'b0000, "R4 clock drop");
      usrclk_ok = 1'b1; run(19); chk(4'b0000, "R4 count restarted");
      run(1); chk(4'b0010, "R4 align after restart");

      // R8: lock loss during coding reset
      restart(1, 1, 0, 0, 0);
      run(88); chk(4'b0100, "R8 pcs before loss");
      tx_lock = 1'b0; run(1); chk(4'b0000, "R8 loss in pcs");
      tx_lock = 1'b1; run(20); chk(4'b0010, "R8 align after pcs loss");

      // R8: lock loss during settle
      restart(1, 1, 0, 0, 0);
      run(92); chk(4'b0000, "R8 in settle");
      tx_lock = 1'b0; run(1); chk(4'b0000, "R8 loss in settle");
      tx_lock = 1'b1; run(4); chk(4'b0000, "R8 no done after settle loss");
      run(16); chk(4'b0010, "R8 align after settle loss");

      // R9: analog gating needs RXS consecutive lock cycles
      restart(1, 1, 1, 1, 0);
      run(RXS); chk(4'b0000, "R9 held before run complete");
      run(1); chk(4'b1000, "R9 start after run");

      // R9: a drop restarts the run
      restart(1, 1, 1, 1, 0);
      run(10);
      rx_lock = 1'b0; run(1); chk(4'b0000, "R9 drop holds idle");
      rx_lock = 1'b1; run(RXS); chk(4'b0000, "R9 run restarted");
      run(1); chk(4'b1000, "R9 start after restarted run");

      // R10: digital gating needs only a high lock
      restart(1, 1, 0, 1, 1);
      run(5); chk(4'b0000, "R10 held while rx_lock low");
      rx_lock = 1'b1; run(1); chk(4'b1000, "R10 start on rx_lock");

      // R2: gating off ignores rx_lock entirely
      restart(1, 1, 0, 0, 1);
      run(1); chk(4'b1000, "R2 start with rx_lock low, gate off");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule